// File: doc/BRIEF.md
# JTAG Test Access Port Controller

This block is the serial test port of a chip. It follows the standard sixteen-state test access port sequence, clocked by the test clock and steered by the mode-select line. It holds a 5-bit instruction register. The decoded instruction selects which data register sits between the serial input and the serial output. The choices are a single-bit bypass stage, a 32-bit identification word, or an external boundary chain.

The boundary chain lives outside the block. The block hands the chain a serial input, capture, shift and update strobes, and a mode line that hands the pins to the chain. It takes back the chain's serial output. The identification word carries a fixed part number and manufacturer code. Its top nibble comes from a version input.

Serial output is launched on the falling test-clock edge. An enable marks the output as valid only while a shift state is active. An active-low reset input returns the port to its reset state at any time, whatever the clock is doing.

Top module: `tap_port`

## Requirements
- R1: While `trstN` is low, the port sits in Test-Logic-Reset without waiting for a clock edge: `tdoEn` and `tdo` are 0 and `chainMode` is 0. When it leaves reset, the active instruction is IDCODE (00001), so a data scan returns the identification word.
- R2: Five consecutive rising edges with `tms` high bring the port to Test-Logic-Reset from any state. Once there, the active instruction is IDCODE.
- R3: In Capture-IR the instruction shift register loads 00001. Shift-IR moves it out least significant bit first, so `tdo` shows 1,0,0,0,0, while `tdi` enters at the top.
- R4: Opcodes are 5 bits, shifted in LSB first. 00001 selects the identification register. 00000 (EXTEST) and 00010 (sample/preload) select the boundary chain. 11111 and every other value select the bypass stage.
- R5: The identification word holds, from bit 31 down: `version` in bits 31:28, part number 16'h6462 in bits 27:12, manufacturer code 11'h020 in bits 11:1, and 1 in bit 0. It is shifted out LSB first.
- R6: The bypass stage loads 0 in Capture-DR and delays `tdi` by one Shift-DR cycle.
- R7: With a boundary instruction active, `chainCapture` is high only in Capture-DR and `chainShift` only in Shift-DR, one strobe per rising edge spent in that state. During those shifts `tdo` follows `chainSo` and `chainSi` carries `tdi`.
- R8: `chainUpdate` is high in Update-DR only when a boundary instruction is active. It never pulses for a bypass or identification scan.
- R9: `chainMode` is 1 exactly while EXTEST (00000) is the active instruction. It is 0 under sample/preload, bypass, identification and unknown opcodes.
- R10: `tdo` and `tdoEn` change only on falling `tck` edges. `tdoEn` is 1 only while the port is in Shift-IR or Shift-DR.
- R11: A shifted opcode becomes active at the falling edge in Update-IR. Until then the previous instruction stays in force, including through Shift-IR and Exit1-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous active-low port reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| version | input | 4 | Version nibble for identification bits 31:28 |
| chainSo | input | 1 | Serial output returned by the boundary chain |
| tdo | output | 1 | Serial data out, launched on falling `tck` |
| tdoEn | output | 1 | High while `tdo` carries shift data |
| chainSi | output | 1 | Serial input forwarded to the boundary chain |
| chainCapture | output | 1 | Boundary chain capture strobe |
| chainShift | output | 1 | Boundary chain shift strobe |
| chainUpdate | output | 1 | Boundary chain update strobe (falling-edge use) |
| chainMode | output | 1 | Boundary chain owns the pins (EXTEST) |

## Verification
The assertions assume three things about the inputs. `tms` and `tdi` are stable around each rising `tck` edge. `trstN` is asserted before the first clock edge. `chainSo` changes only after a rising edge, as a shift register would. The stimulus drives `tms` and `tdi` one nanosecond after each falling edge and samples `tdo` just before and just after the next rising edge. It releases `trstN` only just after a falling edge. The 333-cell boundary chain model in the bench updates on the same edges as real chain cells.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;
  localparam int IR_W  = 5;
  localparam int ID_W  = 32;
  localparam int VER_W = 4;
  localparam int PART_W = 16;
  localparam int MFR_W  = 11;

  localparam logic [IR_W-1:0] OP_EXTEST = 5'b00000;
  localparam logic [IR_W-1:0] OP_IDCODE = 5'b00001;
  localparam logic [IR_W-1:0] OP_SAMPLE = 5'b00010;
  localparam logic [IR_W-1:0] OP_BYPASS = 5'b11111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;

  typedef enum logic [3:0] {
    stReset, stIdle,
    stSelDr, stCapDr, stShiftDr, stExit1Dr, stPauseDr, stExit2Dr, stUpdDr,
    stSelIr, stCapIr, stShiftIr, stExit1Ir, stPauseIr, stExit2Ir, stUpdIr
  } tapStateT;

  typedef struct packed {
    logic resetTap;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } tapCtlT;

  typedef struct packed {
    logic selBypass;
    logic selId;
    logic selBoundary;
    logic extest;
  } drSelT;
endpackage

// File: rtl/tap_ctrl.sv
`timescale 1ns/1ps
module tap_ctrl
  import tap_pkg::*;
(
  input  logic     tck,
  input  logic     trstN,
  input  logic     tms,
  output tapStateT state,
  output tapCtlT   ctl
);
  tapStateT nxt;

  always_comb begin
    case (state)
      stReset:   nxt = tms ? stReset   : stIdle;
      stIdle:    nxt = tms ? stSelDr   : stIdle;
      stSelDr:   nxt = tms ? stSelIr   : stCapDr;
      stCapDr:   nxt = tms ? stExit1Dr : stShiftDr;
      stShiftDr: nxt = tms ? stExit1Dr : stShiftDr;
      stExit1Dr: nxt = tms ? stUpdDr   : stPauseDr;
      stPauseDr: nxt = tms ? stExit2Dr : stPauseDr;
      stExit2Dr: nxt = tms ? stUpdDr   : stShiftDr;
      stUpdDr:   nxt = tms ? stSelDr   : stIdle;
      stSelIr:   nxt = tms ? stReset   : stCapIr;
      stCapIr:   nxt = tms ? stExit1Ir : stShiftIr;
      stShiftIr: nxt = tms ? stExit1Ir : stShiftIr;
      stExit1Ir: nxt = tms ? stUpdIr   : stPauseIr;
      stPauseIr: nxt = tms ? stExit2Ir : stPauseIr;
      stExit2Ir: nxt = tms ? stUpdIr   : stShiftIr;
      stUpdIr:   nxt = tms ? stSelDr   : stIdle;
      default:   nxt = stReset;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= stReset;
    else        state <= nxt;
  end

  always_comb begin
    ctl           = '0;
    ctl.resetTap  = (state == stReset);
    ctl.captureIr = (state == stCapIr);
    ctl.shiftIr   = (state == stShiftIr);
    ctl.updateIr  = (state == stUpdIr);
    ctl.captureDr = (state == stCapDr);
    ctl.shiftDr   = (state == stShiftDr);
    ctl.updateDr  = (state == stUpdDr);
  end

  // checker support: run length of tms-high edges, saturating at 5
  logic [2:0] onesCnt;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            onesCnt <= '0;
    else if (!tms)         onesCnt <= '0;
    else if (onesCnt != 3'd5) onesCnt <= onesCnt + 3'd1;
  end

  a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!trstN)
    (onesCnt == 3'd5) |-> (state == stReset));

  a_r2_reset_holds: assert property (@(posedge tck) disable iff (!trstN)
    (state == stReset && tms) |=> (state == stReset));

  a_r2_reset_leaves_idle: assert property (@(posedge tck) disable iff (!trstN)
    (state == stReset && !tms) |=> (state == stIdle));
endmodule

// File: rtl/tap_decode.sv
`timescale 1ns/1ps
module tap_decode
  import tap_pkg::*;
(
  input  logic [IR_W-1:0] irActive,
  output drSelT           sel
);
  always_comb begin
    sel = '0;
    case (irActive)
      OP_IDCODE: sel.selId = 1'b1;
      OP_EXTEST: begin
        sel.selBoundary = 1'b1;
        sel.extest      = 1'b1;
      end
      OP_SAMPLE: sel.selBoundary = 1'b1;
      default:   sel.selBypass = 1'b1;
    endcase
  end

  always_comb begin
    a_r4_one_path: assert ($onehot({sel.selBypass, sel.selId, sel.selBoundary}));
  end
endmodule

// File: rtl/tap_datapath.sv
`timescale 1ns/1ps
module tap_datapath
  import tap_pkg::*;
#(
  parameter logic [PART_W-1:0] PART_NUM = 16'h6462,
  parameter logic [MFR_W-1:0]  MFR_ID   = 11'h020
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tdi,
  input  logic [VER_W-1:0] version,
  input  logic             chainSo,
  input  tapCtlT           ctl,
  input  drSelT            sel,
  output logic [IR_W-1:0]  irActive,
  output logic             tdo,
  output logic             tdoEn,
  output logic             chainSi,
  output logic             chainCapture,
  output logic             chainShift,
  output logic             chainUpdate,
  output logic             chainMode
);
  logic [IR_W-1:0] irShift;
  logic            bypassBit;
  logic [ID_W-1:0] idShift;
  logic [ID_W-1:0] idWord;
  logic            drOut;
  logic            nextTdo;

  assign idWord = {version, PART_NUM, MFR_ID, 1'b1};

  // instruction shift stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)             irShift <= IR_CAPTURE;
    else if (ctl.captureIr) irShift <= IR_CAPTURE;
    else if (ctl.shiftIr)   irShift <= {tdi, irShift[IR_W-1:1]};
  end

  // active instruction changes on the falling edge only
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)            irActive <= OP_IDCODE;
    else if (ctl.resetTap) irActive <= OP_IDCODE;
    else if (ctl.updateIr) irActive <= irShift;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) bypassBit <= 1'b0;
    else if (sel.selBypass) begin
      if (ctl.captureDr)    bypassBit <= 1'b0;
      else if (ctl.shiftDr) bypassBit <= tdi;
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) idShift <= '0;
    else if (sel.selId) begin
      if (ctl.captureDr)    idShift <= idWord;
      else if (ctl.shiftDr) idShift <= {tdi, idShift[ID_W-1:1]};
    end
  end

  always_comb begin
    if (sel.selBoundary) drOut = chainSo;
    else if (sel.selId)  drOut = idShift[0];
    else                 drOut = bypassBit;
    nextTdo = ctl.shiftIr ? irShift[0] : drOut;
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= ctl.shiftIr | ctl.shiftDr;
      tdo   <= (ctl.shiftIr | ctl.shiftDr) ? nextTdo : 1'b0;
    end
  end

  assign chainSi      = tdi;
  assign chainCapture = ctl.captureDr & sel.selBoundary;
  assign chainShift   = ctl.shiftDr   & sel.selBoundary;
  assign chainUpdate  = ctl.updateDr  & sel.selBoundary;
  assign chainMode    = sel.extest;

  a_r3_capture_ir: assert property (@(posedge tck) disable iff (!trstN)
    ctl.captureIr |=> (irShift == IR_CAPTURE));

  a_r6_bypass_zero: assert property (@(posedge tck) disable iff (!trstN)
    (ctl.captureDr && sel.selBypass) |=> (bypassBit == 1'b0));

  a_r5_id_low_bits: assert property (@(posedge tck) disable iff (!trstN)
    (ctl.captureDr && sel.selId) |=> (idShift[0] && idShift[MFR_W:1] == MFR_ID));

  a_r10_enable_in_shift: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn == (ctl.shiftIr || ctl.shiftDr));

  a_r11_instr_change_window: assert property (@(posedge tck) disable iff (!trstN)
    !$stable(irActive) |-> (ctl.updateIr || ctl.resetTap));

  a_r9_mode_on_boundary: assert property (@(posedge tck) disable iff (!trstN)
    chainMode |-> (irActive == OP_EXTEST));
endmodule

// File: rtl/tap_port.sv
`timescale 1ns/1ps
module tap_port
  import tap_pkg::*;
#(
  parameter logic [PART_W-1:0] PART_NUM = 16'h6462,
  parameter logic [MFR_W-1:0]  MFR_ID   = 11'h020
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tms,
  input  logic             tdi,
  input  logic [VER_W-1:0] version,
  input  logic             chainSo,
  output logic             tdo,
  output logic             tdoEn,
  output logic             chainSi,
  output logic             chainCapture,
  output logic             chainShift,
  output logic             chainUpdate,
  output logic             chainMode
);
  tapStateT        state;
  tapCtlT          ctl;
  drSelT           sel;
  logic [IR_W-1:0] irActive;

  tap_ctrl u_ctrl (
    .tck   (tck),
    .trstN (trstN),
    .tms   (tms),
    .state (state),
    .ctl   (ctl)
  );

  tap_decode u_decode (
    .irActive (irActive),
    .sel      (sel)
  );

  tap_datapath #(
    .PART_NUM (PART_NUM),
    .MFR_ID   (MFR_ID)
  ) u_data (
    .tck          (tck),
    .trstN        (trstN),
    .tdi          (tdi),
    .version      (version),
    .chainSo      (chainSo),
    .ctl          (ctl),
    .sel          (sel),
    .irActive     (irActive),
    .tdo          (tdo),
    .tdoEn        (tdoEn),
    .chainSi      (chainSi),
    .chainCapture (chainCapture),
    .chainShift   (chainShift),
    .chainUpdate  (chainUpdate),
    .chainMode    (chainMode)
  );

  a_r7_strobes_exclusive: assert property (@(posedge tck) disable iff (!trstN)
    !(chainCapture && chainShift) && !(chainShift && chainUpdate));

  a_r8_update_after_exit: assert property (@(posedge tck) disable iff (!trstN)
    chainUpdate |-> (state == stUpdDr));
endmodule

// File: tb/sim_tap_port.sv
`timescale 1ns/1ps
module sim_tap_port;
  localparam int CHAIN_LEN = 333;
  localparam int VEC_W     = 512;
  localparam int BIG_SCAN  = 340;

  logic       tck = 1'b0;
  logic       trstN = 1'b0;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic [3:0] version = 4'hA;
  logic       chainSo;
  logic       tdo, tdoEn, chainSi, chainCapture, chainShift, chainUpdate, chainMode;

  always #10 tck = ~tck;

  tap_port u0 (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .version(version),
    .chainSo(chainSo), .tdo(tdo), .tdoEn(tdoEn), .chainSi(chainSi),
    .chainCapture(chainCapture), .chainShift(chainShift),
    .chainUpdate(chainUpdate), .chainMode(chainMode)
  );

  // boundary chain model
  logic [CHAIN_LEN-1:0] chain = '0;
  logic [CHAIN_LEN-1:0] updLatch = '0;
  logic [CHAIN_LEN-1:0] pins;
  int capCount = 0, shiftCount = 0, updCount = 0;
  assign chainSo = chain[0];

  always @(posedge tck) begin
    if (chainCapture) begin
      chain <= pins;
      capCount++;
    end else if (chainShift) begin
      chain <= {chainSi, chain[CHAIN_LEN-1:1]};
      shiftCount++;
    end
  end

  always @(negedge tck) begin
    if (chainUpdate) begin
      updLatch <= chain;
      updCount++;
    end
  end

  typedef struct {
    bit    chkEn;
    bit    expEn;
    bit    chkData;
    bit    expData;
    string tag;
  } itemT;
  itemT q[$];

  int nChecks = 0, nFails = 0;
  logic [VEC_W-1:0] idWord, dinA, dinB;
  logic [4:0] irCap = 5'b00001;

  task automatic chk(bit ok, string tag, logic [VEC_W-1:0] act, logic [VEC_W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per cycle and compares
  initial begin
    itemT it;
    forever begin
      @(negedge tck);
      #8;
      if (q.size() > 0) begin
        it = q.pop_front();
        if (it.chkEn)
          chk(tdoEn === it.expEn, {it.tag, " enable"}, VEC_W'(tdoEn), VEC_W'(it.expEn));
        if (it.chkData) begin
          chk(tdo === it.expData, it.tag, VEC_W'(tdo), VEC_W'(it.expData));
          #4;
          chk(tdo === it.expData, "R10 tdo held across rising edge", VEC_W'(tdo), VEC_W'(it.expData));
        end
      end
    end
  end

  // driver: one test clock, with the expectation for the current state
  task automatic clk(bit tmsV, bit tdiV, bit cEn, bit eEn, bit cData, bit eData, string tag);
    itemT it;
    @(negedge tck);
    #1;
    tms = tmsV;
    tdi = tdiV;
    it.chkEn = cEn; it.expEn = eEn; it.chkData = cData; it.expData = eData; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(bit tmsV);
    clk(tmsV, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10 enable low outside shift");
  endtask

  task automatic irScan(logic [4:0] code, output bit modeAtExit);
    step(1); step(1); step(0); step(0);
    for (int i = 0; i < 5; i++)
      clk(i == 4, code[i], 1'b1, 1'b1, 1'b1, irCap[i], "R3 instruction capture");
    step(1);
    #2 modeAtExit = chainMode;
    step(0);
  endtask

  task automatic drScan(int len, logic [VEC_W-1:0] capt, int nBits,
                        logic [VEC_W-1:0] din, string tag);
    bit e;
    step(1); step(0); step(0);
    for (int i = 0; i < nBits; i++) begin
      if (i < len) e = capt[i];
      else         e = din[i-len];
      clk(i == nBits-1, din[i], 1'b1, 1'b1, 1'b1, e, tag);
    end
    step(1); step(0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    bit m;
    int cap0, sh0, upd0;
    logic [CHAIN_LEN-1:0] expUpd;

    for (int i = 0; i < CHAIN_LEN; i++) pins[i] = ((i * 7) % 5) < 2;
    for (int i = 0; i < VEC_W; i++) begin
      dinA[i] = ((i * 5 + 3) % 7) < 3;
      dinB[i] = ((i * 3 + 1) % 4) == 0;
    end
    idWord = VEC_W'({4'hA, 16'h6462, 11'h020, 1'b1});

    // R1 reset state
    #25;
    chk(tdoEn === 1'b0, "R1 enable low in reset", VEC_W'(tdoEn), 0);
    chk(chainMode === 1'b0, "R1 mode low in reset", VEC_W'(chainMode), 0);
    chk(tdo === 1'b0, "R1 tdo low in reset", VEC_W'(tdo), 0);
    @(negedge tck); #1 trstN = 1'b1;
    step(0);
    drScan(32, idWord, 40, dinA, "R5 identification word after reset R1");

    // R4 / R6 bypass
    irScan(5'b11111, m);
    chk(chainMode === 1'b0, "R4 bypass not extest", VEC_W'(chainMode), 0);
    upd0 = updCount;
    drScan(1, '0, 12, dinA, "R6 bypass one-bit delay");
    chk(updCount == upd0, "R8 no chain update for bypass", VEC_W'(updCount), VEC_W'(upd0));

    // R7 / R8 sample-preload through the boundary chain
    irScan(5'b00010, m);
    chk(chainMode === 1'b0, "R9 mode low under sample", VEC_W'(chainMode), 0);
    cap0 = capCount; sh0 = shiftCount; upd0 = updCount;
    drScan(CHAIN_LEN, VEC_W'(pins), BIG_SCAN, dinB, "R7 boundary chain data");
    chk(capCount - cap0 == 1, "R7 one capture strobe", VEC_W'(capCount - cap0), 1);
    chk(shiftCount - sh0 == BIG_SCAN, "R7 shift strobe count", VEC_W'(shiftCount - sh0), VEC_W'(BIG_SCAN));
    chk(updCount - upd0 == 1, "R8 one update strobe", VEC_W'(updCount - upd0), 1);
    for (int j = 0; j < CHAIN_LEN; j++) expUpd[j] = dinB[j + BIG_SCAN - CHAIN_LEN];
    chk(updLatch === expUpd, "R8 updated chain contents", VEC_W'(updLatch), VEC_W'(expUpd));

    // R9 / R11 extest
    irScan(5'b00000, m);
    chk(m == 1'b0, "R11 mode unchanged before update", VEC_W'(m), 0);
    chk(chainMode === 1'b1, "R9 mode high under extest", VEC_W'(chainMode), 1);
    cap0 = capCount;
    drScan(CHAIN_LEN, VEC_W'(pins), CHAIN_LEN, dinA, "R7 boundary under extest");
    chk(capCount - cap0 == 1, "R7 extest capture", VEC_W'(capCount - cap0), 1);

    // R4 unknown opcode
    irScan(5'b00111, m);
    chk(m == 1'b1, "R11 extest kept through shift", VEC_W'(m), 1);
    chk(chainMode === 1'b0, "R4 unknown opcode not extest", VEC_W'(chainMode), 0);
    upd0 = updCount;
    drScan(1, '0, 6, dinA, "R4 unknown opcode acts as bypass");
    chk(updCount == upd0, "R8 no update for unknown opcode", VEC_W'(updCount), VEC_W'(upd0));

    irScan(5'b00001, m);
    drScan(32, idWord, 32, dinA, "R4 identification opcode");

    // R2 escape from Shift-IR with tms high
    irScan(5'b11111, m);
    step(1); step(1); step(0); step(0);
    for (int i = 0; i < 5; i++) clk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 escape");
    step(0);
    chk(chainMode === 1'b0, "R2 mode low after tms reset", VEC_W'(chainMode), 0);
    drScan(32, idWord, 36, dinB, "R2 identification after tms reset");

    // R1 asynchronous reset in Shift-DR under extest
    irScan(5'b00000, m);
    chk(chainMode === 1'b1, "R9 extest reloaded", VEC_W'(chainMode), 1);
    step(1); step(0); step(0);
    clk(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1 shift before reset");
    #1;
    chk(tdoEn === 1'b1, "R10 enable high in shift", VEC_W'(tdoEn), 1);
    #1 trstN = 1'b0;
    #1;
    chk(tdoEn === 1'b0, "R1 async enable drop", VEC_W'(tdoEn), 0);
    chk(chainMode === 1'b0, "R1 async mode drop", VEC_W'(chainMode), 0);
    chk(tdo === 1'b0, "R1 async tdo clear", VEC_W'(tdo), 0);
    @(negedge tck); #1 trstN = 1'b1;
    step(0);
    drScan(32, idWord, 32, dinA, "R1 identification after async reset");

    repeat (3) @(negedge tck);
    summary();
    $finish;
  end
endmodule